// File: doc/BRIEF.md
# Hexadecimal Count Display

A free-running binary counter whose value is shown on two seven-segment digits and one decimal point. The counter is nine bits wide and advances by one on every rising clock edge. The eight low bits appear as two hexadecimal digits. The top bit lights the decimal point, so the full range 0 to 511 can be read from the display as two hex digits with the point acting as a ninth bit.

Reset is asynchronous and active low. It clears the counter at once, with no clock edge needed. Every segment output and the decimal-point output are active low, so a 0 on a pin lights that segment. Each digit has its own combinational decoder fed from the registered count, so the outputs change only after a clock edge or a reset. Debouncing, display multiplexing and clock generation belong to the surrounding logic.

Top module: `hexdisp_top`

## Requirements
- R1: While rst_n is 0 the count is 0: both digits show the glyph for 0 (seg value 7'h40) and dp_n is 1. Asserting rst_n takes effect at once, with no clock edge, and holds across clock edges.
- R2: After rst_n goes to 1, each rising clock edge adds one to the count. The first edge after release gives a count of 1.
- R3: When the count is 511, the next edge gives 0, with no stall or skipped state.
- R4: seg_lo shows count bits [3:0] and seg_hi shows count bits [7:4].
- R5: dp_n is 0 exactly when count bit 8 is 1.
- R6: Outputs are active low, and output bit i drives segment i. Segment 0 is the top, 1 the upper right, 2 the lower right, 3 the bottom, 4 the lower left, 5 the upper left and 6 the middle.
- R7: The numeral glyphs light these segments. 0: {0,1,2,3,4,5}. 1: {1,2}. 2: {0,1,3,4,6}. 3: {0,1,2,3,6}. 4: {1,2,5,6}. 5: {0,2,3,5,6}. 6: {0,2,3,4,5,6}. 7: {0,1,2}. 8: all seven. 9: {0,1,2,3,5,6}.
- R8: The letter glyphs light these segments. A (10): {0,1,2,4,5,6}. Lowercase b (11): {2,3,4,5,6}. C (12): {0,3,4,5}. Lowercase d (13): {1,2,3,4,6}. E (14): {0,3,4,5,6}. F (15): {0,4,5,6}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the count advances on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_hi | output | 7 | Left digit segments (count bits [7:4]), active low |
| seg_lo | output | 7 | Right digit segments (count bits [3:0]), active low |
| dp_n | output | 1 | Decimal point (count bit 8), active low |

## Verification
The bench builds the block with its default nine-bit count. With that width, one full period of 512 states fits in a run of about six hundred cycles. The walk passes through every glyph on both digits, sees the decimal point both dark and lit, and crosses the wrap from 511 back to 0 in one run. Directed steps then drop reset in the middle of a clock phase to show that it clears the display at once, and check that it holds over later edges.

// File: rtl/hexdisp_pkg.sv
package hexdisp_pkg;
  localparam int NIB_W = 4;
  localparam int SEG_N = 7;

  // Lit-segment mask for one hex nibble; bit i = segment i, 1 = lit.
  function automatic logic [SEG_N-1:0] glyph_lit(input logic [NIB_W-1:0] v);
    logic [SEG_N-1:0] m;
    case (v)
      4'h0: m = 7'b0111111;
      4'h1: m = 7'b0000110;
      4'h2: m = 7'b1011011;
      4'h3: m = 7'b1001111;
      4'h4: m = 7'b1100110;
      4'h5: m = 7'b1101101;
      4'h6: m = 7'b1111101;
      4'h7: m = 7'b0000111;
      4'h8: m = 7'b1111111;
      4'h9: m = 7'b1101111;
      4'hA: m = 7'b1110111;
      4'hB: m = 7'b1111100;
      4'hC: m = 7'b0111001;
      4'hD: m = 7'b1011110;
      4'hE: m = 7'b1111001;
      default: m = 7'b1110001;
    endcase
    return m;
  endfunction

  // Next count value with natural wrap at the register width.
  function automatic logic [15:0] next_count(input logic [15:0] cur, input logic [15:0] max_val);
    return (cur == max_val) ? 16'd0 : cur + 16'd1;
  endfunction
endpackage

// File: rtl/hexdisp_counter.sv
module hexdisp_counter #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] count,
  output logic             at_max
);
  import hexdisp_pkg::*;
  localparam logic [15:0] MAX_VAL = 16'((1 << CNT_W) - 1);

  logic [CNT_W-1:0] count_q;
  logic [15:0]      count_ext;
  logic [15:0]      count_nxt;

  assign count_ext = 16'(count_q);
  assign count_nxt = next_count(count_ext, MAX_VAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_nxt[CNT_W-1:0];
  end

  assign count  = count_q;
  assign at_max = (count_ext == MAX_VAL);
endmodule

// File: rtl/hexdisp_decoder.sv
module hexdisp_decoder #(
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  logic [hexdisp_pkg::NIB_W-1:0] nib,
  output logic [hexdisp_pkg::SEG_N-1:0] seg
);
  import hexdisp_pkg::*;
  logic [SEG_N-1:0] lit;
  assign lit = glyph_lit(nib);

  generate
    if (ACTIVE_LOW) begin : g_low
      assign seg = ~lit;
    end else begin : g_high
      assign seg = lit;
    end
  endgenerate
endmodule

// File: rtl/hexdisp_point.sv
module hexdisp_point #(
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  logic bit_in,
  output logic dp
);
  generate
    if (ACTIVE_LOW) begin : g_low
      assign dp = ~bit_in;
    end else begin : g_high
      assign dp = bit_in;
    end
  endgenerate
endmodule

// File: rtl/hexdisp_top.sv
module hexdisp_top #(
  parameter int CNT_W = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic [6:0] seg_hi,
  output logic [6:0] seg_lo,
  output logic       dp_n
);
  import hexdisp_pkg::*;
  localparam int N_DIGITS = (CNT_W - 1) / NIB_W;
  localparam int DP_BIT   = CNT_W - 1;

  logic [CNT_W-1:0] count_q;
  logic             wrap_evt;
  logic [SEG_N-1:0] digit_seg [N_DIGITS];

  hexdisp_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .count  (count_q),
    .at_max (wrap_evt)
  );

  generate
    for (genvar d = 0; d < N_DIGITS; d++) begin : g_digit
      hexdisp_decoder #(.ACTIVE_LOW(1'b1)) u_dec (
        .nib (count_q[d*NIB_W +: NIB_W]),
        .seg (digit_seg[d])
      );
    end
  endgenerate

  hexdisp_point #(.ACTIVE_LOW(1'b1)) u_dp (
    .bit_in (count_q[DP_BIT]),
    .dp     (dp_n)
  );

  assign seg_lo = digit_seg[0];
  assign seg_hi = digit_seg[N_DIGITS-1];
endmodule

// File: rtl/hexdisp_chk.sv
module hexdisp_chk #(
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic             wrap,
  input logic [6:0]       seg_hi,
  input logic [6:0]       seg_lo,
  input logic             dp_n
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (cnt == '0 && dp_n && seg_lo == 7'h40 && seg_hi == 7'h40));

  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !wrap) |=> (cnt == $past(cnt) + 1'b1));

  assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));

  assert_eight_all_lit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[3:0] == 4'h8) |-> (seg_lo == 7'h00));

  assert_point_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dp_n == !cnt[CNT_W-1]);

  assert_never_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_lo != 7'h7F) && (seg_hi != 7'h7F));

  assert_hi_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt[3:0]) != 4'hF && !$past(wrap)) |-> $stable(seg_hi));
endmodule

bind hexdisp_top hexdisp_chk #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cnt    (count_q),
  .wrap   (wrap_evt),
  .seg_hi (seg_hi),
  .seg_lo (seg_lo),
  .dp_n   (dp_n)
);

// File: tb/sim_hexdisp_top.sv
`timescale 1ns/1ps
module sim_hexdisp_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] seg_hi, seg_lo;
  logic dp_n;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Active-low glyphs, bit i = segment i (R6, R7, R8).
  localparam logic [6:0] GLYPH_N [16] = '{
    7'h40, 7'h79, 7'h24, 7'h30, 7'h19, 7'h12, 7'h02, 7'h78,
    7'h00, 7'h10, 7'h08, 7'h03, 7'h46, 7'h21, 7'h06, 7'h0E
  };

  hexdisp_top u0 (.clk(clk), .rst_n(rst_n), .seg_hi(seg_hi), .seg_lo(seg_lo), .dp_n(dp_n));

  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_count(input string tag, input int c);
    string dig_tag;
    dig_tag = (c[3:0] > 4'd9) ? "R8" : "R7";
    chk({tag, " lo R4 ", dig_tag}, int'(seg_lo), int'(GLYPH_N[c[3:0]]));
    chk({tag, " hi R4 R6"}, int'(seg_hi), int'(GLYPH_N[c[7:4]]));
    chk({tag, " dp R5"}, int'(dp_n), int'(!c[8]));
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_count("R1 reset state", 0);
    rst_n = 1'b1;
    // R2 R3: walk more than one full period; count = cycles since release.
    for (int k = 1; k <= 600; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk_count(k == 512 ? "R3 wrap" : "R2 walk", k % 512);
    end
    // R1: asynchronous assertion mid-phase.
    @(posedge clk);
    #3 rst_n = 1'b0;
    #2 chk_count("R1 async clear", 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk_count("R1 hold", 0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk_count("R2 first after release", 1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule